// File: doc/BRIEF.md
# Base-Index Effective Address Generator

This block forms the memory address for a load, store or jump. The request carries a memory opcode, a 3-bit base selector, a 3-bit index selector and a signed displacement. The block adds three terms: the base, the index and the displacement after sign extension. It reads the base and index operands through combinational read ports. These ports cover eight 64-bit address registers and integer data registers 1 to 3.

The sum is registered once, together with an access-size code decoded from the opcode and a flag for natural-alignment violations. A misaligned access raises the flag, but the address is still delivered. The register files, address translation and the memory access itself belong to neighbouring blocks.

Top module: `eag_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `ea_valid`, `ea_addr`, `ea_misaligned` and `ea_size` are all zero.
- R2: A request sampled with `req_valid` high at a rising edge shows its results, with `ea_valid` high, after that same edge. `ea_valid` is low after any edge at which `req_valid` was low.
- R3: A base field of 1 to 7 adds address register 1 to 7. A base field of 000 adds zero; address register 0 is never used as a base.
- R4: An index field of 000 adds no index. Index codes 001, 010 and 011 add integer data registers 1, 2 and 3.
- R5: Index codes 100, 101, 110 and 111 add address registers 0, 1, 2 and 3.
- R6: `ea_addr` is base + index + sign-extended `req_disp`, computed modulo 2^64 so that it wraps.
- R7: `ea_size` codes are 0 for 8 bits, 1 for 16, 2 for 32, 3 for 64, 4 for 128 and 5 for 48. Opcodes 00000 to 01111 map by their bits [3:2] to codes 0 to 3. Opcodes 10000/10001 give 48 bits, 10010/10011 give 32, 10100/10101 give 64 and 10110/10111 give 128.
- R8: For the 16-, 32-, 64- and 128-bit sizes, `ea_misaligned` is 1 exactly when the address is not a multiple of the access size in bytes. Byte accesses are never misaligned.
- R9: A 48-bit access is misaligned exactly when `ea_addr[0]` is 1.
- R10: Opcodes 11000 to 11111 give `ea_size` = 7 and `ea_misaligned` = 0.
- R11: While `req_valid` is low, `ea_addr`, `ea_size` and `ea_misaligned` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_opcode | input | 5 | Memory opcode |
| req_base | input | 3 | Base selector |
| req_index | input | 3 | Index selector |
| req_disp | input | DISP_W (16) | Signed displacement |
| areg_flat | input | 8*ADDR_W (512) | Address registers, register n at bits [n*64 +: 64] |
| dreg1 | input | ADDR_W (64) | Integer data register 1 |
| dreg2 | input | ADDR_W (64) | Integer data register 2 |
| dreg3 | input | ADDR_W (64) | Integer data register 3 |
| ea_valid | output | 1 | Registered results valid |
| ea_addr | output | ADDR_W (64) | Effective address |
| ea_misaligned | output | 1 | Alignment violation |
| ea_size | output | 3 | Access-size code |

## Verification
Every result is due exactly one rising edge after the request is sampled. The results are the address, the size code and the misalignment flag, and `ea_valid` marks them.

The bench drives each request on a falling edge and removes `req_valid` on the next falling edge. It samples the outputs at that moment, half a period after the single register has loaded. After an idle cycle it samples once more, which confirms that `ea_valid` has dropped while the other outputs hold.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [2:0] {
    SZ_B8    = 3'd0,
    SZ_H16   = 3'd1,
    SZ_W32   = 3'd2,
    SZ_L64   = 3'd3,
    SZ_Q128  = 3'd4,
    SZ_M48   = 3'd5,
    SZ_RSVD  = 3'd6,
    SZ_NONE  = 3'd7
  } size_e;

  // Opcode to access size. Integer opcodes group in fours; float opcodes in pairs.
  function automatic size_e size_of_op(input logic [4:0] op);
    size_e s;
    if (!op[4]) begin
      s = size_e'({1'b0, op[3:2]});
    end else if (!op[3]) begin
      case (op[2:1])
        2'b00:   s = SZ_M48;
        2'b01:   s = SZ_W32;
        2'b10:   s = SZ_L64;
        default: s = SZ_Q128;
      endcase
    end else begin
      s = SZ_NONE;
    end
    return s;
  endfunction

  // Low address bits that must be zero for an access of the given size.
  function automatic logic [3:0] align_mask(input size_e s);
    logic [3:0] m;
    case (s)
      SZ_H16, SZ_M48: m = 4'h1;
      SZ_W32:         m = 4'h3;
      SZ_L64:         m = 4'h7;
      SZ_Q128:        m = 4'hF;
      default:        m = 4'h0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/eag_operand_sel.sv
module eag_operand_sel #(
  parameter int ADDR_W = 64,
  parameter int NUM_AREG = 8
) (
  input  logic [2:0]                 base_sel,
  input  logic [2:0]                 index_sel,
  input  logic [NUM_AREG*ADDR_W-1:0] areg_flat,
  input  logic [ADDR_W-1:0]          dreg1,
  input  logic [ADDR_W-1:0]          dreg2,
  input  logic [ADDR_W-1:0]          dreg3,
  output logic [ADDR_W-1:0]          base_val,
  output logic [ADDR_W-1:0]          index_val
);

  logic [ADDR_W-1:0] areg [NUM_AREG];

  for (genvar g = 0; g < NUM_AREG; g++) begin : g_unpack
    assign areg[g] = areg_flat[g*ADDR_W +: ADDR_W];
  end

  // Base: code 0 means no base, never address register 0.
  always_comb begin
    if (base_sel == 3'd0) base_val = '0;
    else                  base_val = areg[base_sel];
  end

  // Index: mixed encoding across the two register banks.
  always_comb begin
    case (index_sel)
      3'd0:    index_val = '0;
      3'd1:    index_val = dreg1;
      3'd2:    index_val = dreg2;
      3'd3:    index_val = dreg3;
      default: index_val = areg[{1'b0, index_sel[1:0]}];
    endcase
  end

endmodule

// File: rtl/eag_size_decode.sv
module eag_size_decode
  import eag_pkg::*;
(
  input  logic [4:0] opcode,
  output size_e      size,
  output logic [3:0] mask
);

  assign size = size_of_op(opcode);
  assign mask = align_mask(size);

endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 16,
  parameter int NUM_AREG = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [4:0]                 req_opcode,
  input  logic [2:0]                 req_base,
  input  logic [2:0]                 req_index,
  input  logic [DISP_W-1:0]          req_disp,
  input  logic [NUM_AREG*ADDR_W-1:0] areg_flat,
  input  logic [ADDR_W-1:0]          dreg1,
  input  logic [ADDR_W-1:0]          dreg2,
  input  logic [ADDR_W-1:0]          dreg3,
  output logic                       ea_valid,
  output logic [ADDR_W-1:0]          ea_addr,
  output logic                       ea_misaligned,
  output logic [2:0]                 ea_size
);

  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] base_val;
  logic [ADDR_W-1:0] index_val;
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] sum_w;
  size_e             size_w;
  logic [3:0]        mask_w;
  logic              misalign_w;
  logic              plain_req_w;  // no base and no index
  logic              opcode_ok_w;

  eag_operand_sel #(.ADDR_W(ADDR_W), .NUM_AREG(NUM_AREG)) u_sel (
    .base_sel  (req_base),
    .index_sel (req_index),
    .areg_flat (areg_flat),
    .dreg1     (dreg1),
    .dreg2     (dreg2),
    .dreg3     (dreg3),
    .base_val  (base_val),
    .index_val (index_val)
  );

  eag_size_decode u_dec (
    .opcode (req_opcode),
    .size   (size_w),
    .mask   (mask_w)
  );

  assign disp_ext    = {{EXT_W{req_disp[DISP_W-1]}}, req_disp};
  assign sum_w       = base_val + index_val + disp_ext;
  assign misalign_w  = |(sum_w[3:0] & mask_w);
  assign plain_req_w = (req_base == 3'd0) && (req_index == 3'd0);
  assign opcode_ok_w = !(req_opcode[4] && req_opcode[3]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_valid      <= 1'b0;
      ea_addr       <= '0;
      ea_misaligned <= 1'b0;
      ea_size       <= 3'd0;
    end else begin
      ea_valid <= req_valid;
      if (req_valid) begin
        ea_addr       <= sum_w;
        ea_misaligned <= misalign_w;
        ea_size       <= size_w;
      end
    end
  end

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ea_valid); // R2
  AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !ea_valid); // R2
  AST_DISP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && plain_req_w) |=> (ea_addr == $past(disp_ext))); // R3
  AST_SIZE_DEFINED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && opcode_ok_w) |=> (ea_size != 3'd7)); // R7
  AST_RSVD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !opcode_ok_w) |=> (ea_size == 3'd7 && !ea_misaligned)); // R10
  AST_MEDIUM_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && ea_size == 3'd5) |-> (ea_misaligned == ea_addr[0])); // R9
  AST_BYTE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && ea_size == 3'd0) |-> !ea_misaligned); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(ea_addr) && $stable(ea_size) && $stable(ea_misaligned))); // R11

endmodule

// File: tb/sim_eag_top.sv
module sim_eag_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [4:0]  req_opcode = '0;
  logic [2:0]  req_base = '0;
  logic [2:0]  req_index = '0;
  logic [15:0] req_disp = '0;
  logic [63:0] areg_b [8];
  logic [511:0] areg_flat;
  logic [63:0] dreg1, dreg2, dreg3;
  logic        ea_valid;
  logic [63:0] ea_addr;
  logic        ea_misaligned;
  logic [2:0]  ea_size;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  always_comb for (int i = 0; i < 8; i++) areg_flat[i*64 +: 64] = areg_b[i];

  eag_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_base(req_base), .req_index(req_index), .req_disp(req_disp),
    .areg_flat(areg_flat), .dreg1(dreg1), .dreg2(dreg2), .dreg3(dreg3),
    .ea_valid(ea_valid), .ea_addr(ea_addr), .ea_misaligned(ea_misaligned),
    .ea_size(ea_size)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench-side model, written from the requirements.
  function automatic logic [63:0] exp_addr(input logic [2:0] b, input logic [2:0] x,
                                           input logic [15:0] d);
    logic [63:0] bv, xv;
    bv = (b == 0) ? 64'd0 : areg_b[b];
    if (x == 0)      xv = 64'd0;
    else if (x == 1) xv = dreg1;
    else if (x == 2) xv = dreg2;
    else if (x == 3) xv = dreg3;
    else             xv = areg_b[x - 4];
    return bv + xv + {{48{d[15]}}, d};
  endfunction

  function automatic logic [2:0] exp_size(input logic [4:0] op);
    if (op < 5'd16) return 3'(op / 4);
    if (op < 5'd18) return 3'd5;
    if (op < 5'd20) return 3'd2;
    if (op < 5'd22) return 3'd3;
    if (op < 5'd24) return 3'd4;
    return 3'd7;
  endfunction

  function automatic logic exp_mis(input logic [2:0] sz, input logic [63:0] a);
    case (sz)
      3'd1, 3'd5: return (a % 2) != 0;
      3'd2: return (a % 4) != 0;
      3'd3: return (a % 8) != 0;
      3'd4: return (a % 16) != 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic issue(input string req, input logic [4:0] op, input logic [2:0] b,
                       input logic [2:0] x, input logic [15:0] d);
    logic [63:0] ea;
    logic [2:0]  sz;
    ea = exp_addr(b, x, d);
    sz = exp_size(op);
    @(negedge clk);
    req_valid = 1; req_opcode = op; req_base = b; req_index = x; req_disp = d;
    @(negedge clk);
    req_valid = 0;
    chk({req, " R2 valid"}, {63'd0, ea_valid}, 64'd1);
    chk({req, " addr"}, ea_addr, ea);
    chk({req, " R7 size"}, {61'd0, ea_size}, {61'd0, sz});
    chk({req, " R8 misaligned"}, {63'd0, ea_misaligned}, {63'd0, exp_mis(sz, ea)});
  endtask

  task automatic t_reset();
    chk("R1 valid", {63'd0, ea_valid}, 0);
    chk("R1 addr", ea_addr, 0);
    chk("R1 mis", {63'd0, ea_misaligned}, 0);
    chk("R1 size", {61'd0, ea_size}, 0);
  endtask

  task automatic t_base();
    for (int b = 0; b < 8; b++) issue("R3 base", 5'b01000, 3'(b), 3'd0, 16'h0010);
  endtask

  task automatic t_index_data();
    for (int x = 0; x < 4; x++) issue("R4 index data", 5'b01100, 3'd2, 3'(x), 16'h0008);
  endtask

  task automatic t_index_addr();
    for (int x = 4; x < 8; x++) issue("R5 index areg", 5'b00000, 3'd5, 3'(x), 16'h0001);
  endtask

  task automatic t_wrap();
    issue("R6 negative disp", 5'b00000, 3'd1, 3'd0, 16'hFFF0);
    issue("R6 wrap", 5'b01100, 3'd7, 3'd3, 16'h0020);
    chk("R6 wrap literal", ea_addr, 64'h0000_0000_0000_0013);
  endtask

  task automatic t_sizes();
    for (int op = 0; op < 32; op++) issue("R7/R10 opcode", 5'(op), 3'd1, 3'd0, 16'h0000);
  endtask

  task automatic t_align();
    // R8: each natural size at aligned and off-by-2/off-by-8 offsets
    issue("R8 half odd", 5'b00100, 3'd0, 3'd0, 16'h0101);
    issue("R8 word off2", 5'b01000, 3'd0, 3'd0, 16'h0102);
    issue("R8 long off4", 5'b01101, 3'd0, 3'd0, 16'h0104);
    issue("R8 quad off8", 5'b10110, 3'd0, 3'd0, 16'h0108);
    chk("R8 quad off8 flag", {63'd0, ea_misaligned}, 64'd1);
    issue("R8 quad ok", 5'b10111, 3'd0, 3'd0, 16'h0110);
    chk("R8 quad ok flag", {63'd0, ea_misaligned}, 64'd0);
    issue("R8 byte odd", 5'b00001, 3'd0, 3'd0, 16'h0103);
    // R9: 48-bit needs only 16-bit alignment
    issue("R9 medium off2", 5'b10000, 3'd0, 3'd0, 16'h0102);
    chk("R9 medium off2 flag", {63'd0, ea_misaligned}, 64'd0);
    issue("R9 medium odd", 5'b10001, 3'd0, 3'd0, 16'h0105);
    chk("R9 medium odd flag", {63'd0, ea_misaligned}, 64'd1);
    issue("R10 reserved odd", 5'b11010, 3'd0, 3'd0, 16'h0107);
    chk("R10 reserved flag", {63'd0, ea_misaligned}, 64'd0);
  endtask

  task automatic t_hold();
    logic [63:0] a;
    logic [2:0]  s;
    logic        m;
    issue("R11 setup", 5'b01000, 3'd0, 3'd0, 16'h0006);
    a = ea_addr; s = ea_size; m = ea_misaligned;
    req_opcode = 5'b00100; req_base = 3'd3; req_disp = 16'h1235;
    @(negedge clk);
    chk("R2 valid low when idle", {63'd0, ea_valid}, 0);
    chk("R11 addr held", ea_addr, a);
    chk("R11 size held", {61'd0, ea_size}, {61'd0, s});
    chk("R11 mis held", {63'd0, ea_misaligned}, {63'd0, m});
  endtask

  initial begin
    for (int i = 0; i < 8; i++) areg_b[i] = 64'h0000_1000_0000_0000 + 64'(i) * 64'h0000_0000_0001_0100;
    areg_b[7] = 64'hFFFF_FFFF_FFFF_FFF0;
    dreg1 = 64'h0000_0000_0000_2000;
    dreg2 = 64'h0000_0000_0003_0000;
    dreg3 = 64'h0000_0000_0000_0003;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_base();
    t_index_data();
    t_index_addr();
    t_wrap();
    t_sizes();
    t_align();
    t_hold();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule